// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block decides which of five peripheral interrupt sources an 8-bit processor core should service next, and when. The sources are two external pins, two timer overflows and a serial port. Requests are captured once per machine cycle and judged in the following machine cycle. The judgement uses a global enable, one enable bit per source and one priority bit per source. The block also considers which priority levels are already being serviced.

A winning request becomes a call offer: a 16-bit vector address plus the level it belongs to. The offer is presented on a valid/ready pair. The core takes it by raising `call_ready` while `call_valid` is high. When the core accepts, the block marks that level as in service. A return-from-interrupt strobe later releases the innermost level. Pushing the program counter, clearing the peripheral flags and saving registers are the core's job.

Back-pressure rules: `call_valid` never drops and `call_vec`/`call_hi` never change until the offer is accepted. While an offer is outstanding, no new arbitration takes place. A transfer happens on the rising clock edge where both `call_valid` and `call_ready` are high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `call_valid`, `busy_hi` and `busy_lo` are 0.
- R2: When bit 7 of `en_reg` is 0, no call is offered, whatever the other bits hold. Bits 6 and 5 of `en_reg` and bits 7..5 of `pri_reg` have no effect.
- R3: Source index k uses bit k of both `en_reg` and `pri_reg`: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. A source whose enable bit is 0 is never offered. A priority bit of 1 means high level and 0 means low level.
- R4: `src_req` is captured only on a cycle with `tick_s5` high. Arbitration uses that capture and happens only on a cycle with `tick_s1` high. `call_valid` rises on the clock edge that ends that `tick_s1` cycle. A request that falls before the next `tick_s5` is never seen.
- R5: A high-level candidate always beats a low-level one. Within a level, the lowest source index wins.
- R6: `call_vec` is 0x0003 + 8 × index, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. `call_hi` is 1 for a high-level offer.
- R7: While `busy_lo` is set, only high-level requests can be offered. While `busy_hi` is set, nothing is offered.
- R8: An accepted offer sets `busy_hi` if `call_hi` is 1, and sets `busy_lo` otherwise.
- R9: A `reti_stb` pulse clears `busy_hi` if it is set, and clears `busy_lo` otherwise.
- R10: While `call_valid` is high and `call_ready` is low, the offer is held unchanged. No other offer replaces it, even if requests or registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | Raw request flags, index as in R3 |
| en_reg | input | 8 | Enable register (bit 7 global) |
| pri_reg | input | 8 | Priority register (1 = high) |
| tick_s5 | input | 1 | Capture pulse, once per machine cycle |
| tick_s1 | input | 1 | Arbitration pulse, in the following machine cycle |
| reti_stb | input | 1 | Return-from-interrupt pulse |
| call_valid | output | 1 | Call offer valid |
| call_ready | input | 1 | Core accepts the offer |
| call_vec | output | 16 | Vector address of the offer |
| call_hi | output | 1 | Level of the offer (1 = high) |
| busy_hi | output | 1 | High level in service |
| busy_lo | output | 1 | Low level in service |

## Verification
The assertions check, on every cycle, the properties that follow from the ports alone. An offer never appears without the global enable, and never appears outside an arbitration pulse. An offer never appears while the high level is busy, and a pending offer holds steady under back-pressure. The vector always has a legal form, and the busy flags move correctly on accept and on return. Only the bench scenarios can show which source actually wins. Those scenarios cover polling order, high beating low, low being blocked by low, and individual enables. They also show that a request which disappears before capture is lost.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC     = 5;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
  localparam int VEC_STEP = 8;

  typedef struct packed {
    logic             hi;
    logic [IDX_W-1:0] idx;
  } offer_t;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_BASE + VEC_W'(VEC_STEP) * VEC_W'(idx);
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [N-1:0] raw,
  output logic [N-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)   held <= '0;
    else if (cap) held <= raw;
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan from the top so the lowest set bit is last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic busy_hi,
  output logic busy_lo
);
  logic nx_hi, nx_lo;

  always_comb begin
    nx_hi = busy_hi;
    nx_lo = busy_lo;
    if (ret) begin
      if (busy_hi) nx_hi = 1'b0;
      else         nx_lo = 1'b0;
    end
    if (take) begin
      if (take_hi) nx_hi = 1'b1;
      else         nx_lo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_hi <= 1'b0;
      busy_lo <= 1'b0;
    end else begin
      busy_hi <= nx_hi;
      busy_lo <= nx_lo;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int GLB_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [REG_W-1:0]  en_reg,
  input  logic [REG_W-1:0]  pri_reg,
  input  logic              tick_s5,
  input  logic              tick_s1,
  input  logic              reti_stb,
  output logic              call_valid,
  input  logic              call_ready,
  output logic [VEC_W-1:0]  call_vec,
  output logic              call_hi,
  output logic              busy_hi,
  output logic              busy_lo
);
  localparam int NLVL = 2;

  logic [NSRC-1:0]  smp;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  cand   [NLVL];
  logic             found  [NLVL];
  logic [IDX_W-1:0] win    [NLVL];
  logic             take_hi_now, take_lo_now, launch, accept;
  offer_t           offer_q;

  irq_sampler #(.N(NSRC)) u_smp (
    .clk(clk), .rst_n(rst_n), .cap(tick_s5), .raw(src_req), .held(smp)
  );

  assign elig = smp & en_reg[NSRC-1:0] & {NSRC{en_reg[GLB_BIT]}};

  // level 1 = high, level 0 = low
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (l == 1) begin : g_hi
      assign cand[l] = elig & pri_reg[NSRC-1:0];
    end else begin : g_lo
      assign cand[l] = elig & ~pri_reg[NSRC-1:0];
    end
    irq_level_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
      .cand(cand[l]), .found(found[l]), .idx(win[l])
    );
  end

  assign take_hi_now = found[1] && !busy_hi;
  assign take_lo_now = !found[1] && found[0] && !busy_hi && !busy_lo;
  assign launch      = tick_s1 && !call_valid && (take_hi_now || take_lo_now);
  assign accept      = call_valid && call_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_valid <= 1'b0;
      offer_q    <= '0;
    end else if (launch) begin
      call_valid  <= 1'b1;
      offer_q.hi  <= take_hi_now;
      offer_q.idx <= take_hi_now ? win[1] : win[0];
    end else if (accept) begin
      call_valid <= 1'b0;
    end
  end

  assign call_vec = vec_of(offer_q.idx);
  assign call_hi  = offer_q.hi;

  irq_nest_track u_nest (
    .clk(clk), .rst_n(rst_n), .take(accept), .take_hi(offer_q.hi),
    .ret(reti_stb), .busy_hi(busy_hi), .busy_lo(busy_lo)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  en_reg,
  input logic        tick_s1,
  input logic        reti_stb,
  input logic        call_valid,
  input logic        call_ready,
  input logic [15:0] call_vec,
  input logic        call_hi,
  input logic        busy_hi,
  input logic        busy_lo
);
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(en_reg[7]));

  a_r4_only_on_s1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(tick_s1));

  a_r6_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_vec[15:6] == '0 && call_vec[2:0] == 3'b011 && call_vec[5:3] <= 3'd4));

  a_r7_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> !$past(busy_hi));

  a_r8_accept_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && call_ready && !reti_stb) |=> (call_hi ? busy_hi : busy_lo));

  a_r9_reti_pops_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_stb && busy_hi && !(call_valid && call_ready)) |=> !busy_hi && $stable(busy_lo));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && !call_ready) |=> call_valid && $stable(call_vec) && $stable(call_hi));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .tick_s1(tick_s1),
  .reti_stb(reti_stb), .call_valid(call_valid), .call_ready(call_ready),
  .call_vec(call_vec), .call_hi(call_hi), .busy_hi(busy_hi), .busy_lo(busy_lo)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_req = '0;
  logic [7:0]  en_reg = '0, pri_reg = '0;
  logic        tick_s5 = 1'b0, tick_s1 = 1'b0, reti_stb = 1'b0, call_ready = 1'b0;
  logic        call_valid, call_hi, busy_hi, busy_lo;
  logic [15:0] call_vec;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_reg(en_reg), .pri_reg(pri_reg),
    .tick_s5(tick_s5), .tick_s1(tick_s1), .reti_stb(reti_stb), .call_valid(call_valid),
    .call_ready(call_ready), .call_vec(call_vec), .call_hi(call_hi),
    .busy_hi(busy_hi), .busy_lo(busy_lo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one machine cycle: capture pulse then arbitration pulse
  task automatic mcycle();
    step(); tick_s5 = 1'b1;
    step(); tick_s5 = 1'b0; tick_s1 = 1'b1;
    step(); tick_s1 = 1'b0;
  endtask

  // scoreboard driver: push expected offer, then accept it
  task automatic take(input string req, input logic [15:0] vec, input logic hi);
    chk({req, " offer present"}, 32'(call_valid), 32'd1);
    if (call_valid) begin
      exp_q.push_back({hi, vec});
      call_ready = 1'b1;
      step();
      call_ready = 1'b0;
    end
  endtask

  task automatic reti();
    reti_stb = 1'b1; step(); reti_stb = 1'b0;
  endtask

  // monitor: pops on every transfer, sampled away from the rising edge
  always @(negedge clk) begin
    if (call_valid && call_ready) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R5 unexpected offer actual=%h expected=none", call_vec);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk("R6 vector/level", {15'd0, call_hi, call_vec}, {15'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset valid", 32'(call_valid), 0);
    chk("R1 reset busy", {30'd0, busy_hi, busy_lo}, 0);

    // R2: global enable off blocks everything
    en_reg = 8'h1F; src_req = 5'h1F; mcycle();
    chk("R2 global off", 32'(call_valid), 0);

    // R2/R5: reserved bits set, polling order within low level
    en_reg = 8'hFF; pri_reg = 8'h00; src_req = 5'b10001; mcycle();
    take("R5 low ext0 first", 16'h0003, 1'b0);
    src_req = '0;
    chk("R8 busy_lo set", {30'd0, busy_hi, busy_lo}, 1);

    // R7: low request blocked while low busy
    src_req = 5'b00010; mcycle();
    chk("R7 low blocks low", 32'(call_valid), 0);

    // R7: high preempts low
    pri_reg = 8'hF0; src_req = 5'b10010; mcycle();
    take("R7 high preempts", 16'h0023, 1'b1);
    src_req = '0;
    chk("R8 busy_hi set", {30'd0, busy_hi, busy_lo}, 3);

    // R7: high busy blocks high
    pri_reg = 8'h04; src_req = 5'b00100; mcycle();
    chk("R7 high blocks all", 32'(call_valid), 0);

    // R9: returns unwind hi then lo
    src_req = '0; mcycle();
    reti();
    chk("R9 reti pops hi", {30'd0, busy_hi, busy_lo}, 1);
    reti();
    chk("R9 reti pops lo", {30'd0, busy_hi, busy_lo}, 0);

    // R5: high beats lower-indexed low
    en_reg = 8'h9F; pri_reg = 8'h08; src_req = 5'b01001; mcycle();
    take("R5 high wins", 16'h001B, 1'b1);
    src_req = '0; reti();

    // R3: disabled source skipped
    en_reg = 8'h9E; pri_reg = 8'h00; src_req = 5'b00011; mcycle();
    take("R3 enable mask", 16'h000B, 1'b0);
    src_req = '0; reti();

    // R4: pulse that falls before capture is lost
    en_reg = 8'h9F; mcycle();
    step(); src_req = 5'b00100; step(); src_req = '0;
    mcycle();
    chk("R4 missed pulse", 32'(call_valid), 0);

    // R4: capture without arbitration pulse offers nothing
    src_req = 5'b00100; step(); tick_s5 = 1'b1; step(); tick_s5 = 1'b0;
    repeat (3) step();
    chk("R4 no s1 no call", 32'(call_valid), 0);
    tick_s1 = 1'b1; step(); tick_s1 = 1'b0;
    chk("R4 call after s1", 32'(call_valid), 1);

    // R10: offer held under back-pressure despite changes
    src_req = 5'b00001; pri_reg = 8'h01;
    mcycle(); repeat (4) step();
    chk("R10 held vec", {16'd0, call_vec}, 32'h0013);
    chk("R10 held valid", 32'(call_valid), 1);
    take("R10 accept held", 16'h0013, 1'b0);
    src_req = '0; reti();
    chk("R9 clean end", {30'd0, busy_hi, busy_lo}, 0);

    repeat (3) step();
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule